// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor and a word-addressed main memory. Each 16-bit processor address selects one of 128 lines and one of 16 words within that line. A small tag, kept per line, records which memory block currently occupies the line. Read hits return data one cycle after the request is accepted. A write hit only touches the cached copy and marks the line modified.

When a request misses, the controller first deals with the old line. If that line is modified, all sixteen of its words are copied back to memory. The controller then refills the line one word at a time over a single-word memory port whose latency varies. On a read miss, the requested word goes to the processor in the same cycle it arrives from memory, while the rest of the line continues to load. A write miss fetches the whole block first, then merges the written word into it and marks the line modified.

The processor side uses a valid/ready request handshake and a one-cycle response strobe for reads. The memory side issues one request at a time: a write completes at its handshake, and a read waits for a response strobe.

Top module: `dm_wb_cache`

## Requirements
- R1: Address bits [3:0] select the word within a line, bits [10:4] select the line and bits [15:11] form the tag. Every read returns the value most recently written to that address, whether by the processor or by the initial memory contents.
- R2: A read that hits asserts `cpu_rsp_valid` exactly one cycle after the request handshake, and it issues no memory request.
- R3: A write that hits updates only the cached word and marks the line dirty. Memory sees no write for it until the line is replaced.
- R4: A miss refills the line with sixteen single-word memory reads at {tag, line, w}, with w rising from 0 to 15.
- R5: On a read miss, the requested word appears on `cpu_rsp_rdata` with `cpu_rsp_valid` high in the cycle `mem_rsp_valid` delivers that word. `cpu_req_ready` stays low until the last word of the line has arrived.
- R6: Replacing a valid dirty line first issues sixteen memory writes at {old tag, line, w}, with w from 0 to 15. Replacing a clean or invalid line issues no memory write.
- R7: A write miss fetches the whole block, stores the written word in place of the fetched one, and leaves the line dirty.
- R8: After reset, `cpu_req_ready` is high, no response or memory request is pending, every line is invalid and clean, and the first access to any line misses.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request (valid, direction, address) is held unchanged.
- R10: `cpu_req_ready` is low in every cycle in which a memory request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 16 | Word address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | Read data valid this cycle |
| cpu_rsp_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | 16 | Memory word address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_rdata | input | 32 | Memory read data |

## Verification
Early-restart delivery of the requested word and the continuing refill of the same line fall in the same cycle. In that cycle the processor must already hold its data while the controller still refuses new requests.

The bench provokes this with a read miss to a mid-line word. It then queues a second read to the same line straight after the response. It judges the result in three ways: the response appears while `cpu_req_ready` is still low, the refill still issues all sixteen reads in order, and the queued read is served as a hit that returns reference-model data.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 128,
  parameter int WORDS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_ASK, S_WAIT} st_t;

  st_t               st_q;
  logic [OFF_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ra_q;
  logic              rwe_q;
  logic [DATA_W-1:0] rwd_q;
  logic [LINES-1:0]  vld_q, dty_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES*WORDS];
  logic              hit_rsp_q;
  logic [DATA_W-1:0] hit_dat_q;

  wire [OFF_W-1:0] in_off = cpu_req_addr[OFF_W-1:0];
  wire [IDX_W-1:0] in_idx = cpu_req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] in_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] r_off  = ra_q[OFF_W-1:0];
  wire [IDX_W-1:0] r_idx  = ra_q[OFF_W +: IDX_W];
  wire [TAG_W-1:0] r_tag  = ra_q[ADDR_W-1 -: TAG_W];

  wire in_hit = vld_q[in_idx] && (tag_q[in_idx] == in_tag);
  wire accept = cpu_req_valid && cpu_req_ready;
  wire last   = &cnt_q;
  wire arrive = (st_q == S_WAIT) && mem_rsp_valid;
  wire mine   = cnt_q == r_off;
  wire early  = arrive && mine && !rwe_q;
  wire [DATA_W-1:0] fill_word = (rwe_q && mine) ? rwd_q : mem_rsp_rdata;

  assign cpu_req_ready = st_q == S_IDLE;
  assign cpu_rsp_valid = hit_rsp_q || early;
  assign cpu_rsp_rdata = early ? mem_rsp_rdata : hit_dat_q;
  assign mem_req_valid = (st_q == S_EVICT) || (st_q == S_ASK);
  assign mem_req_we    = st_q == S_EVICT;
  assign mem_req_addr  = {(st_q == S_EVICT) ? tag_q[r_idx] : r_tag, r_idx, cnt_q};
  assign mem_req_wdata = dat_q[{r_idx, cnt_q}];

  always_ff @(posedge clk) begin
    if (accept && in_hit && cpu_req_we) dat_q[{in_idx, in_off}] <= cpu_req_wdata;
    if (arrive) dat_q[{r_idx, cnt_q}] <= fill_word;
    if (arrive && last) tag_q[r_idx] <= r_tag;
    hit_dat_q <= dat_q[{in_idx, in_off}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      ra_q      <= '0;
      rwe_q     <= 1'b0;
      rwd_q     <= '0;
      vld_q     <= '0;
      dty_q     <= '0;
      hit_rsp_q <= 1'b0;
    end else begin
      hit_rsp_q <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          ra_q  <= cpu_req_addr;
          rwe_q <= cpu_req_we;
          rwd_q <= cpu_req_wdata;
          cnt_q <= '0;
          if (in_hit) begin
            if (cpu_req_we) dty_q[in_idx] <= 1'b1;
            else hit_rsp_q <= 1'b1;
          end else begin
            vld_q[in_idx] <= 1'b0;
            st_q <= (vld_q[in_idx] && dty_q[in_idx]) ? S_EVICT : S_ASK;
          end
        end
        S_EVICT: if (mem_req_ready) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            st_q <= S_ASK;
            dty_q[r_idx] <= 1'b0;
          end
        end
        S_ASK: if (mem_req_ready) st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            st_q <= S_IDLE;
            vld_q[r_idx] <= 1'b1;
            dty_q[r_idx] <= rwe_q;
          end else begin
            st_q <= S_ASK;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready);

  a_r6_wb_line: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_addr[OFF_W +: IDX_W] == r_idx);

  a_r4_fill_block: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we |-> mem_req_addr[ADDR_W-1:OFF_W] == ra_q[ADDR_W-1:OFF_W]);

  a_r5_early_word: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT) && mem_rsp_valid && !rwe_q && (cnt_q == ra_q[OFF_W-1:0])
      |-> cpu_rsp_valid && (cpu_rsp_rdata == mem_rsp_rdata));

  a_r7_alloc_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    arrive && last && rwe_q |=> dty_q[$past(r_idx)] && vld_q[$past(r_idx)]);
endmodule

// File: tb/dm_wb_cache_tb.sv
module dm_wb_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [15:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_we;
  logic [15:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  always #2 clk = ~clk;

  dm_wb_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata));

  int checks = 0, errors = 0;
  int nrd = 0, nwr = 0, hold_bad = 0;
  logic [31:0] memw [int];
  logic [31:0] refm [int];
  int rdlog [$];

  function automatic logic [31:0] init_val(input logic [15:0] a);
    return {~a, a ^ 16'h5A3C};
  endfunction
  function automatic logic [31:0] mem_rd(input logic [15:0] a);
    return memw.exists(int'(a)) ? memw[int'(a)] : init_val(a);
  endfunction
  function automatic logic [31:0] ref_rd(input logic [15:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : init_val(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;
  logic        pend = 1'b0;
  logic [15:0] pend_a = '0;
  logic [1:0]  wait_c = '0;
  logic        pv_stall = 1'b0, pv_we = 1'b0;
  logic [15:0] pv_addr = '0;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready <= lfsr[0] | lfsr[3];
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      pend <= 1'b0;
      pv_stall <= 1'b0;
    end else begin
      if (pv_stall && !(mem_req_valid && mem_req_addr == pv_addr && mem_req_we == pv_we)) hold_bad++;
      pv_stall <= mem_req_valid && !mem_req_ready;
      pv_addr  <= mem_req_addr;
      pv_we    <= mem_req_we;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          memw[int'(mem_req_addr)] = mem_req_wdata;
          nwr++;
        end else begin
          pend   <= 1'b1;
          pend_a <= mem_req_addr;
          wait_c <= lfsr[2:1];
          nrd++;
          rdlog.push_back(int'(mem_req_addr));
        end
      end
      if (pend) begin
        if (wait_c == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mem_rd(pend_a);
          pend <= 1'b0;
        end else wait_c <= wait_c - 2'd1;
      end
    end
  end

  task automatic cpu_read(input logic [15:0] a, output logic [31:0] d, output int lat, output logic rdy_at);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = a;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 1;
    while (!cpu_rsp_valid) begin @(negedge clk); lat++; end
    d = cpu_rsp_rdata;
    rdy_at = cpu_req_ready;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [31:0] v);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = a; cpu_req_wdata = v;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    refm[int'(a)] = v;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  logic [31:0] d;
  int lat;
  logic rdy;

  task automatic t_reset();
    chk(cpu_req_ready === 1'b1, "R8 ready after reset", 32'(cpu_req_ready), 1);
    chk(cpu_rsp_valid === 1'b0, "R8 no response after reset", 32'(cpu_rsp_valid), 0);
    chk(mem_req_valid === 1'b0, "R8 no memory request after reset", 32'(mem_req_valid), 0);
  endtask

  task automatic t_cold_miss();
    int r0 = nrd;
    bit ord = 1;
    rdlog.delete();
    cpu_read(16'h0125, d, lat, rdy);
    chk(d === ref_rd(16'h0125), "R1 R5 early-restart data", d, ref_rd(16'h0125));
    chk(rdy === 1'b0, "R5 ready low while line still filling", 32'(rdy), 0);
    cpu_read(16'h0129, d, lat, rdy);
    chk(d === ref_rd(16'h0129), "R10 queued read after refill", d, ref_rd(16'h0129));
    chk(nrd - r0 == 16, "R4 sixteen refill reads", nrd - r0, 16);
    for (int i = 0; i < 16; i++)
      if (i >= rdlog.size() || rdlog[i] != 32'h0120 + i) ord = 0;
    chk(ord, "R4 refill addresses ascend over the block", rdlog.size(), 16);
  endtask

  task automatic t_hit();
    int r0 = nrd;
    cpu_read(16'h0123, d, lat, rdy);
    chk(d === ref_rd(16'h0123), "R2 hit data", d, ref_rd(16'h0123));
    chk(lat == 1, "R2 hit latency one cycle", lat, 1);
    chk(nrd == r0, "R2 hit makes no memory read", nrd - r0, 0);
  endtask

  task automatic t_write_hit();
    int w0 = nwr;
    cpu_write(16'h0127, 32'hDEAD_0127);
    cpu_read(16'h0127, d, lat, rdy);
    chk(d === 32'hDEAD_0127, "R3 write hit visible to reads", d, 32'hDEAD_0127);
    chk(mem_rd(16'h0127) === init_val(16'h0127), "R3 memory untouched by write hit", mem_rd(16'h0127), init_val(16'h0127));
    chk(nwr == w0, "R3 no memory write on hit", nwr - w0, 0);
  endtask

  task automatic t_dirty_evict();
    int w0 = nwr;
    cpu_read(16'h0925, d, lat, rdy);
    wait_idle();
    chk(d === ref_rd(16'h0925), "R1 conflicting block data", d, ref_rd(16'h0925));
    chk(nwr - w0 == 16, "R6 dirty line writes sixteen words", nwr - w0, 16);
    chk(mem_rd(16'h0127) === 32'hDEAD_0127, "R6 written-back word at old address", mem_rd(16'h0127), 32'hDEAD_0127);
    w0 = nwr;
    cpu_read(16'h0127, d, lat, rdy);
    wait_idle();
    chk(nwr == w0, "R6 clean line replaced without writes", nwr - w0, 0);
    chk(d === 32'hDEAD_0127, "R1 value survives eviction", d, 32'hDEAD_0127);
  endtask

  task automatic t_write_miss();
    int r0 = nrd;
    int w0 = nwr;
    cpu_write(16'h3A4C, 32'hBEEF_3A4C);
    wait_idle();
    chk(nrd - r0 == 16, "R7 write miss fetches the block", nrd - r0, 16);
    chk(!memw.exists(32'h3A4C), "R7 write miss does not write memory", nwr - w0, 0);
    r0 = nrd;
    cpu_read(16'h3A4C, d, lat, rdy);
    chk(d === 32'hBEEF_3A4C && nrd == r0, "R7 merged word hits", d, 32'hBEEF_3A4C);
    cpu_read(16'h3A4D, d, lat, rdy);
    chk(d === ref_rd(16'h3A4D), "R7 neighbour word from memory", d, ref_rd(16'h3A4D));
    w0 = nwr;
    cpu_read(16'h324C, d, lat, rdy);
    wait_idle();
    chk(nwr - w0 == 16 && mem_rd(16'h3A4C) === 32'hBEEF_3A4C, "R7 allocated line is dirty", mem_rd(16'h3A4C), 32'hBEEF_3A4C);
  endtask

  task automatic t_sweep();
    int bad = 0;
    logic [31:0] exp = '0, act = '0;
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a = 16'(i * 16'h1F3B + 16'h0411);
      if (i % 3 == 1) cpu_write(a, {16'hC0DE, a});
      else begin
        cpu_read(a, d, lat, rdy);
        if (d !== ref_rd(a)) begin bad++; act = d; exp = ref_rd(a); end
      end
    end
    chk(bad == 0, "R1 mixed sweep against reference", act, exp);
  endtask

  task automatic t_reset_again();
    int r0;
    cpu_read(16'h0000, d, lat, rdy);
    wait_idle();
    do_reset();
    refm = memw;
    t_reset();
    r0 = nrd;
    cpu_read(16'h0000, d, lat, rdy);
    wait_idle();
    chk(nrd - r0 == 16, "R8 first access after reset misses", nrd - r0, 16);
    chk(d === ref_rd(16'h0000), "R8 data after reset", d, ref_rd(16'h0000));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_cold_miss();
    t_hit();
    t_write_hit();
    t_dirty_evict();
    t_write_miss();
    t_sweep();
    t_reset_again();
    chk(hold_bad == 0, "R9 stalled memory request held", hold_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule